// File: doc/BRIEF.md
# Zero-Address Stack Expression Evaluator

This block is a small execution core that evaluates arithmetic expressions held on an internal operand stack. It steps through a program word by word from an instruction read port. Only data values live on the stack. The operation to perform always comes from the instruction word itself. Load and store instructions carry an absolute data-memory address. The four arithmetic instructions carry no operand field: they always consume the two newest stack entries and leave one result in their place.

The stack is register-based: eight 16-bit slots plus an occupancy counter. The newest two slots are read directly by the arithmetic unit. Data memory is synchronous, so a read returns its word one cycle after the request. A `done` output reports a normal stop. An `error` output is sticky and reports stack misuse or division by zero. Misuse of the stack freezes the core. Division by zero lets the program run on.

Instruction word: the opcode sits in bits [15:12] and the memory address in bits [7:0]. Opcodes are 0 no-op, 1 load-to-stack, 2 store-from-stack, 3 add, 4 subtract, 5 multiply, 6 divide, 15 stop. Every other opcode behaves as a no-op.

Top module: `stk_eval_core`

## Requirements
- R1: While reset is held, `done`, `error`, `dmem_rd_en` and `dmem_wr_en` are 0 and `imem_addr` is 0. After release, the first instruction is fetched from address 0.
- R2: Opcode 1 reads the data word at address bits [7:0] and places it on top of the stack. It takes 3 cycles: fetch, memory read, stack write.
- R3: Opcode 2 writes the top entry to the data word at address bits [7:0] and removes it from the stack. It takes 2 cycles. Entries come back in reverse order of loading.
- R4: Opcodes 3, 4 and 5 compute next-below-top plus, minus or times top, keeping the low 16 bits. The result replaces both operands, so the depth drops by one. Each takes 2 cycles.
- R5: Opcode 6 divides next-below-top by top as signed 16-bit values, truncating toward zero and keeping the low 16 bits. It takes 2 cycles.
- R6: A divide by zero leaves 0 in place of its two operands, sets `error`, and lets execution continue.
- R7: An arithmetic opcode with fewer than two entries, or a store with an empty stack, sets `error` and freezes the core. After that, no further fetch, no memory access, and `done` stays 0.
- R8: A load when all 8 entries are occupied sets `error` and freezes the core in the same way. A load into the eighth slot is legal.
- R9: Opcode 15 raises `done` at the end of its second cycle. After that, `imem_addr` holds and no further instruction runs. Opcodes 0 and 7 to 14 change no state and take 2 cycles.
- R10: Once set, `error` stays 1 until reset.
- R11: A read and a write to data memory are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Address of the next instruction word |
| imem_data | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 8 | Data memory word address |
| dmem_rd_en | output | 1 | Read request; data expected on `dmem_rdata` one cycle later |
| dmem_wr_en | output | 1 | Write request of `dmem_wdata` at `dmem_addr` |
| dmem_wdata | output | 16 | Data written by a store |
| dmem_rdata | input | 16 | Read data, registered by the memory |
| done | output | 1 | Program reached the stop opcode |
| error | output | 1 | Sticky fault flag |

## Verification
The assertions check, on every cycle, the structural rules:
- a read and a write are never requested together;
- `done` and `error` stay set once set;
- the depth never exceeds eight slots;
- each load grows the depth by one two cycles after its read request;
- each store and each arithmetic step shrinks the depth by one;
- a freeze raises `error` and holds the fetch address.

Only the bench scenarios can show that the values are right. The bench sweeps every pairing of a signed operand set through all four operators. It also checks operand order, LIFO order at full depth, the exact cycle at which `done` rises, and that stores issued after a freeze never reach memory.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LOAD = 4'd1,
    OP_STOR = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_MUL  = 4'd5,
    OP_DIV  = 4'd6,
    OP_STOP = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_EXEC,
    ST_LOAD,
    ST_DONE,
    ST_FAULT
  } core_state_e;

  localparam int OPC_W = 4;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [W-1:0]     lhs,
  input  logic [W-1:0]     rhs,
  output logic [W-1:0]     res,
  output logic             div_zero
);

  function automatic logic [W-1:0] f_quot(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W-1:0] sa;
    logic signed [W-1:0] sb;
    sa = a;
    sb = b;
    if (b == '0) return '0;
    return W'(sa / sb);
  endfunction

  function automatic logic [W-1:0] f_eval(input logic [OPC_W-1:0] op,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return W'(a * b);
      OP_DIV:  return f_quot(a, b);
      default: return '0;
    endcase
  endfunction

  assign res      = f_eval(opc, lhs, rhs);
  assign div_zero = (opc == OP_DIV) && (rhs == '0);

endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic             pop_en,
  input  logic             fold_en,
  input  logic [W-1:0]     push_data,
  input  logic [W-1:0]     fold_data,
  output logic [W-1:0]     top_q,
  output logic [W-1:0]     below_q,
  output logic [CNT_W-1:0] depth,
  output logic             full,
  output logic             empty,
  output logic             two_ok
);

  logic [CNT_W-1:0] depth_q;
  logic [IDX_W-1:0] wr_idx, top_idx, below_idx;
  logic [W-1:0]     slot_w [DEPTH];

  assign wr_idx    = IDX_W'(depth_q);
  assign top_idx   = IDX_W'(depth_q - CNT_W'(1));
  assign below_idx = IDX_W'(depth_q - CNT_W'(2));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (push_en && (wr_idx == IDX_W'(i))) begin
        q <= push_data;
      end else if (fold_en && (below_idx == IDX_W'(i))) begin
        q <= fold_data;
      end
    end
    assign slot_w[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (push_en) begin
      depth_q <= depth_q + CNT_W'(1);
    end else if (pop_en || fold_en) begin
      depth_q <= depth_q - CNT_W'(1);
    end
  end

  assign top_q   = slot_w[top_idx];
  assign below_q = slot_w[below_idx];
  assign depth   = depth_q;
  assign full    = (depth_q == CNT_W'(DEPTH));
  assign empty   = (depth_q == '0);
  assign two_ok  = (depth_q >= CNT_W'(2));

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int PC_W    = 8,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  input  logic               full,
  input  logic               empty,
  input  logic               two_ok,
  input  logic               div_zero,
  output logic [PC_W-1:0]    pc,
  output logic [OPC_W-1:0]   opc,
  output logic [ADDR_W-1:0]  maddr,
  output logic               rd_en,
  output logic               wr_en,
  output logic               push_en,
  output logic               pop_en,
  output logic               fold_en,
  output logic               fault_ev,
  output logic               done,
  output logic               error
);

  core_state_e        st_q, st_d;
  logic [PC_W-1:0]    pc_q;
  logic [OPC_W-1:0]   opc_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               done_q, err_q;
  logic               set_err, set_done;
  logic               unused_field;

  assign unused_field = ^instr[INSTR_W-OPC_W-1:ADDR_W];

  always_comb begin
    st_d     = st_q;
    rd_en    = 1'b0;
    wr_en    = 1'b0;
    push_en  = 1'b0;
    pop_en   = 1'b0;
    fold_en  = 1'b0;
    fault_ev = 1'b0;
    set_err  = 1'b0;
    set_done = 1'b0;
    case (st_q)
      ST_FETCH: st_d = ST_EXEC;
      ST_EXEC: begin
        st_d = ST_FETCH;
        case (opc_q)
          OP_LOAD: begin
            if (full) begin
              fault_ev = 1'b1;
              st_d     = ST_FAULT;
            end else begin
              rd_en = 1'b1;
              st_d  = ST_LOAD;
            end
          end
          OP_STOR: begin
            if (empty) begin
              fault_ev = 1'b1;
              st_d     = ST_FAULT;
            end else begin
              wr_en  = 1'b1;
              pop_en = 1'b1;
            end
          end
          OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
            if (!two_ok) begin
              fault_ev = 1'b1;
              st_d     = ST_FAULT;
            end else begin
              fold_en = 1'b1;
              set_err = div_zero;
            end
          end
          OP_STOP: begin
            set_done = 1'b1;
            st_d     = ST_DONE;
          end
          default: st_d = ST_FETCH;
        endcase
      end
      ST_LOAD: begin
        push_en = 1'b1;
        st_d    = ST_FETCH;
      end
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_FETCH;
      pc_q   <= '0;
      opc_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_FETCH) begin
        opc_q  <= instr[INSTR_W-1 -: OPC_W];
        addr_q <= instr[ADDR_W-1:0];
        pc_q   <= pc_q + PC_W'(1);
      end
      done_q <= done_q | set_done;
      err_q  <= err_q | set_err | fault_ev;
    end
  end

  assign pc    = pc_q;
  assign opc   = opc_q;
  assign maddr = addr_q;
  assign done  = done_q;
  assign error = err_q;

endmodule

// File: rtl/stk_eval_core.sv
module stk_eval_core #(
  parameter int W       = 16,
  parameter int DEPTH   = 8,
  parameter int PC_W    = 8,
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic [ADDR_W-1:0]  dmem_addr,
  output logic               dmem_rd_en,
  output logic               dmem_wr_en,
  output logic [W-1:0]       dmem_wdata,
  input  logic [W-1:0]       dmem_rdata,
  output logic               done,
  output logic               error
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [3:0]       opc_w;
  logic [W-1:0]     top_w, below_w, res_w;
  logic [CNT_W-1:0] depth_w;
  logic             full_w, empty_w, two_w, dz_w;
  logic             push_ev, pop_ev, alu_ev, fault_ev;

  stk_ctrl #(.INSTR_W(INSTR_W), .PC_W(PC_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (imem_data),
    .full     (full_w),
    .empty    (empty_w),
    .two_ok   (two_w),
    .div_zero (dz_w),
    .pc       (imem_addr),
    .opc      (opc_w),
    .maddr    (dmem_addr),
    .rd_en    (dmem_rd_en),
    .wr_en    (dmem_wr_en),
    .push_en  (push_ev),
    .pop_en   (pop_ev),
    .fold_en  (alu_ev),
    .fault_ev (fault_ev),
    .done     (done),
    .error    (error)
  );

  stk_regs #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_ev),
    .pop_en    (pop_ev),
    .fold_en   (alu_ev),
    .push_data (dmem_rdata),
    .fold_data (res_w),
    .top_q     (top_w),
    .below_q   (below_w),
    .depth     (depth_w),
    .full      (full_w),
    .empty     (empty_w),
    .two_ok    (two_w)
  );

  stk_alu #(.W(W)) u_alu (
    .opc      (opc_w),
    .lhs      (below_w),
    .rhs      (top_w),
    .res      (res_w),
    .div_zero (dz_w)
  );

  assign dmem_wdata = top_w;

endmodule

// File: rtl/stk_eval_core_chk.sv
module stk_eval_core_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int PC_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  imem_addr,
  input logic             dmem_rd_en,
  input logic             dmem_wr_en,
  input logic             done,
  input logic             error,
  input logic [CNT_W-1:0] depth,
  input logic             alu_ev,
  input logic             fault_ev
);

  p_excl_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_rd_en && dmem_wr_en));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(imem_addr)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  p_depth_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  p_load_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd_en |-> ##2 (depth == $past(depth, 2) + CNT_W'(1)));

  p_store_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr_en |=> (depth == $past(depth) - CNT_W'(1)));

  p_fold_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alu_ev |=> (depth == $past(depth) - CNT_W'(1)));

  p_fault_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> (error && !done && $stable(imem_addr)));

endmodule

bind stk_eval_core stk_eval_core_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .dmem_rd_en (dmem_rd_en),
  .dmem_wr_en (dmem_wr_en),
  .done       (done),
  .error      (error),
  .depth      (depth_w),
  .alu_ev     (alu_ev),
  .fault_ev   (fault_ev)
);

// File: tb/stk_eval_core_tb.sv
`timescale 1ns/1ps
module stk_eval_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr, dmem_addr;
  logic [15:0] imem_data, dmem_wdata;
  logic [15:0] dmem_rdata = '0;
  logic        dmem_rd_en, dmem_wr_en, done, error;

  logic [15:0] rom  [256];
  logic [15:0] dmem [256];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_a = '0;
  logic [15:0] tb_d = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  stk_eval_core u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rd_en(dmem_rd_en), .dmem_wr_en(dmem_wr_en),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .done(done), .error(error)
  );

  assign imem_data = rom[imem_addr];

  always @(posedge clk) begin
    if (tb_we) dmem[tb_a] <= tb_d;
    else if (dmem_wr_en) dmem[dmem_addr] <= dmem_wdata;
    if (dmem_rd_en) dmem_rdata <= dmem[dmem_addr];
  end

  function automatic logic [15:0] ins(input int op, input int a);
    return {op[3:0], 4'h0, a[7:0]};
  endfunction

  function automatic logic [15:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
    int x, y, r;
    x = int'($signed(a));
    y = int'($signed(b));
    case (op)
      3: r = x + y;
      4: r = x - y;
      5: r = x * y;
      default: r = (y == 0) ? 0 : x / y;
    endcase
    return r[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    tb_a = a[7:0]; tb_d = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = ins(15, 0);
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input int cyc);
    rst_n = 1'b1;
    repeat (cyc) @(negedge clk);
  endtask

  logic [15:0] vals [8];
  bit finished = 1'b0;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vals[0] = 16'd0;    vals[1] = 16'd1;    vals[2] = 16'd2;    vals[3] = 16'd7;
    vals[4] = 16'hffff; vals[5] = 16'hfff9; vals[6] = 16'h7fff; vals[7] = 16'h8000;
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    clear_rom();

    // R1: reset state
    hold_reset();
    chk(done == 0 && error == 0 && imem_addr == 0 && !dmem_rd_en && !dmem_wr_en,
        "R1 reset", {done, error, dmem_rd_en, dmem_wr_en}, 0);

    // R2 R4 R5 R9: (A+B)*C/D with exact done cycle
    poke(1, 16'd5); poke(2, 16'd9); poke(3, 16'hfffd); poke(4, 16'd4);
    rom[0] = ins(1, 1); rom[1] = ins(1, 2); rom[2] = ins(3, 0); rom[3] = ins(1, 3);
    rom[4] = ins(5, 0); rom[5] = ins(1, 4); rom[6] = ins(6, 0); rom[7] = ins(2, 50);
    rom[8] = ins(15, 0);
    run(21);
    chk(done == 0, "R9 done not early", done, 0);
    @(negedge clk);
    chk(done == 1, "R9 done at cycle 22", done, 1);
    chk(dmem[50] == 16'hfff6, "R5 expression result", dmem[50], 16'hfff6);
    chk(error == 0, "R4 no error", error, 0);
    repeat (10) @(negedge clk);
    chk(imem_addr == 9 && done == 1, "R9 fetch holds after stop", imem_addr, 9);

    // R4 R5 R6: operator sweep over all operand pairs
    for (int op = 3; op <= 6; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          clear_rom();
          hold_reset();
          poke(10, vals[i]); poke(11, vals[j]); poke(20, 16'h5a5a);
          rom[0] = ins(1, 10); rom[1] = ins(1, 11); rom[2] = ins(op, 0);
          rom[3] = ins(2, 20); rom[4] = ins(15, 0);
          run(14);
          chk(dmem[20] == model(op, vals[i], vals[j]) && done == 1,
              (op == 6) ? "R5 divide sweep" : "R4 arith sweep",
              dmem[20], model(op, vals[i], vals[j]));
          chk(error == (op == 6 && vals[j] == 0), "R6 error flag in sweep",
              error, (op == 6 && vals[j] == 0));
        end
      end
    end

    // R6 R10: divide by zero continues, error sticks
    clear_rom(); hold_reset();
    poke(10, 16'd77); poke(11, 16'd0); poke(12, 16'd33);
    rom[0] = ins(1, 10); rom[1] = ins(1, 11); rom[2] = ins(6, 0); rom[3] = ins(1, 12);
    rom[4] = ins(3, 0);  rom[5] = ins(2, 40); rom[6] = ins(15, 0);
    run(30);
    chk(dmem[40] == 16'd33, "R6 zero placed then add", dmem[40], 33);
    chk(error == 1 && done == 1, "R10 error sticky through run", {error, done}, 3);

    // R7: arithmetic underflow freezes
    clear_rom(); hold_reset();
    poke(30, 16'h1234);
    rom[0] = ins(1, 10); rom[1] = ins(3, 0); rom[2] = ins(2, 30); rom[3] = ins(15, 0);
    run(30);
    chk(error == 1 && done == 0, "R7 underflow flags", {error, done}, 2);
    chk(imem_addr == 2 && dmem[30] == 16'h1234, "R7 frozen no store", dmem[30], 16'h1234);

    // R7: store on empty stack
    clear_rom(); hold_reset();
    poke(31, 16'h4321);
    rom[0] = ins(2, 31); rom[1] = ins(15, 0);
    run(20);
    chk(error == 1 && done == 0 && dmem[31] == 16'h4321, "R7 empty store", dmem[31], 16'h4321);

    // R2 R3 R8: fill to eight, unload in LIFO order
    clear_rom(); hold_reset();
    for (int k = 0; k < 8; k++) poke(60 + k, 16'(100 + k));
    for (int k = 0; k < 8; k++) rom[k] = ins(1, 60 + k);
    for (int k = 0; k < 8; k++) rom[8 + k] = ins(2, 80 + k);
    rom[16] = ins(15, 0);
    run(60);
    chk(error == 0 && done == 1, "R8 eight entries legal", {error, done}, 1);
    for (int k = 0; k < 8; k++)
      chk(dmem[80 + k] == 16'(107 - k), "R3 LIFO order", dmem[80 + k], 16'(107 - k));

    // R8: ninth load faults
    clear_rom(); hold_reset();
    poke(32, 16'hbeef);
    for (int k = 0; k < 9; k++) rom[k] = ins(1, 60);
    rom[9] = ins(2, 32); rom[10] = ins(15, 0);
    run(60);
    chk(error == 1 && done == 0, "R8 overflow flags", {error, done}, 2);
    chk(imem_addr == 9 && dmem[32] == 16'hbeef, "R8 frozen no store", dmem[32], 16'hbeef);

    // R9: no-op and undefined opcodes change nothing, 2 cycles each
    clear_rom(); hold_reset();
    poke(10, 16'h0abc); poke(41, 16'h0);
    rom[0] = ins(1, 10); rom[1] = 16'h7abc; rom[2] = ins(0, 0); rom[3] = 16'h9f11;
    rom[4] = ins(2, 41); rom[5] = ins(15, 0);
    run(12);
    chk(done == 0, "R9 nop timing early", done, 0);
    @(negedge clk);
    chk(done == 1 && error == 0 && dmem[41] == 16'h0abc, "R9 nops inert", dmem[41], 16'h0abc);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule